// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is an iterative 32-bit integer arithmetic engine. It computes products and quotients into a private result pair, HI and LO, and never into a general register. A command carries an operation code and two operands. Multiply, signed or unsigned, writes the 64-bit product across the pair: upper word in HI, lower word in LO. Divide, signed or unsigned, writes the quotient to LO and the remainder to HI. The arithmetic runs one bit per clock. It uses a shift-add multiplier and a restoring divider on operand magnitudes, followed by one cycle that applies signs and commits the result.

Commands enter on a valid/ready port. `cmd_ready` is high exactly when the unit is idle, so back-pressure takes the form of ready held low for the whole computation. A `cmd_valid` presented while busy is not taken and leaves no trace. Results leave on a read port that is also valid/ready. The requester raises `rd_valid` with `rd_sel` picking the half. The transfer happens in any cycle where `rd_ready` is high, and `rd_data` shows the selected half in that same cycle. While the unit is busy, `rd_ready` stays low, so a read stalls until the new result is in place. The requester must hold `rd_valid` and `rd_sel` until ready returns.

Top module: `hilo_muldiv`

## Requirements
- R1: With `cmd_op` 2'b00 (signed) or 2'b01 (unsigned), the unit forms the 64-bit product of `cmd_a` and `cmd_b`. HI receives bits 63..32 and LO receives bits 31..0.
- R2: With `cmd_op` 2'b11 (unsigned divide) and a nonzero divisor, LO receives `cmd_a / cmd_b` and HI receives `cmd_a % cmd_b`.
- R3: With `cmd_op` 2'b10 (signed divide) and a nonzero divisor, the quotient is truncated toward zero and the remainder carries the sign of the dividend. The case 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R4: Division by zero, signed or unsigned, completes without fault. LO becomes 0xFFFFFFFF and HI becomes the dividend unchanged.
- R5: `cmd_ready` is high exactly when `busy` is low. A command accepted on a clock edge makes `busy` high for exactly W+1 = 33 cycles, starting in the following cycle.
- R6: A command presented while `busy` is high is not accepted. It changes neither the timing nor the result of the operation in progress.
- R7: `rd_ready` is low whenever `busy` is high. When `rd_ready` is high, `rd_data` is HI if `rd_sel` = 1 and LO if `rd_sel` = 0, in the same cycle.
- R8: HI and LO keep their values for the whole time `busy` is high. Both change only on the edge where `busy` falls.
- R9: After reset, HI and LO read as zero, `busy` is low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| cmd_a | input | 32 | Multiplicand or dividend |
| cmd_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Computation in progress |
| rd_valid | input | 1 | Read request |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_ready | output | 1 | Read can complete this cycle |
| rd_data | output | 32 | Selected result half |

## Verification
The bench builds the unit with its default width of 32, so expected values come straight from 64-bit integer arithmetic in the bench. Sign-extreme operands such as 0x80000000 and all-ones are applied directly. The 33-cycle busy window is short enough to count per operation. That lets every run confirm the exact latency, and commands and reads can be injected inside the window to probe the stall and ignore rules.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } hilo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } hilo_state_e;

  function automatic logic op_is_div(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_signed(input logic [1:0] op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/hilo_mul_core.sv
// Unsigned shift-add multiplier: one multiplier bit per step.
module hilo_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] acc_hi, acc_lo, mc_r;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mc_r} : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
      mc_r   <= '0;
    end else if (load) begin
      acc_hi <= '0;
      acc_lo <= mplier;
      mc_r   <= mcand;
    end else if (step) begin
      acc_hi <= sum[W:1];
      acc_lo <= {sum[0], acc_lo[W-1:1]};
    end
  end

  assign prod = {acc_hi, acc_lo};
endmodule

// File: rtl/hilo_div_core.sv
// Unsigned restoring divider: one quotient bit per step.
module hilo_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] rem_r, quo_r, dvs_r;
  logic [W:0]   shifted, diff;
  logic         fits;

  always_comb begin
    shifted = {rem_r, quo_r[W-1]};
    diff    = shifted - {1'b0, dvs_r};
    fits    = shifted >= {1'b0, dvs_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_r <= '0;
      quo_r <= '0;
      dvs_r <= '0;
    end else if (load) begin
      rem_r <= '0;
      quo_r <= dividend;
      dvs_r <= divisor;
    end else if (step) begin
      rem_r <= fits ? diff[W-1:0] : shifted[W-1:0];
      quo_r <= {quo_r[W-2:0], fits};
    end
  end

  assign quo = quo_r;
  assign rem = rem_r;
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [1:0]   cmd_op,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  output logic         busy,
  input  logic         rd_valid,
  input  logic         rd_sel,
  output logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  hilo_state_e    state;
  logic [CNT_W-1:0] step_cnt;
  logic [1:0]     op_q;
  logic           a_neg_q, b_neg_q, b_zero_q;
  logic [W-1:0]   a_q;
  logic [W-1:0]   hi_q, lo_q;

  logic           fire, load, step_en;
  logic           sgn_in;
  logic [W-1:0]   mag_a, mag_b;
  logic [2*W-1:0] prod_u, prod_s;
  logic [W-1:0]   quo_u, rem_u, quo_s, rem_s;

  assign busy      = (state != ST_IDLE);
  assign cmd_ready = ~busy;
  assign fire      = cmd_valid & cmd_ready;
  assign load      = fire;
  assign step_en   = (state == ST_RUN);

  // Operand magnitudes for the unsigned cores
  always_comb begin
    sgn_in = op_is_signed(cmd_op);
    mag_a  = (sgn_in && cmd_a[W-1]) ? (~cmd_a + 1'b1) : cmd_a;
    mag_b  = (sgn_in && cmd_b[W-1]) ? (~cmd_b + 1'b1) : cmd_b;
  end

  hilo_mul_core #(.W(W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step_en),
    .mcand  (mag_a),
    .mplier (mag_b),
    .prod   (prod_u)
  );

  hilo_div_core #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step_en),
    .dividend (mag_a),
    .divisor  (mag_b),
    .quo      (quo_u),
    .rem      (rem_u)
  );

  // Sign restoration applied in the finishing cycle
  always_comb begin
    logic sgn;
    sgn    = op_is_signed(op_q);
    prod_s = (sgn && (a_neg_q ^ b_neg_q)) ? (~prod_u + 1'b1) : prod_u;
    quo_s  = (sgn && (a_neg_q ^ b_neg_q)) ? (~quo_u + 1'b1) : quo_u;
    rem_s  = (sgn && a_neg_q) ? (~rem_u + 1'b1) : rem_u;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      op_q     <= '0;
      a_neg_q  <= 1'b0;
      b_neg_q  <= 1'b0;
      b_zero_q <= 1'b0;
      a_q      <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (fire) begin
            state    <= ST_RUN;
            step_cnt <= '0;
            op_q     <= cmd_op;
            a_neg_q  <= cmd_a[W-1];
            b_neg_q  <= cmd_b[W-1];
            b_zero_q <= (cmd_b == '0);
            a_q      <= cmd_a;
          end
        end
        ST_RUN: begin
          if (step_cnt == LAST_STEP) state <= ST_FIX;
          step_cnt <= step_cnt + 1'b1;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          if (!op_is_div(op_q)) begin
            hi_q <= prod_s[2*W-1:W];
            lo_q <= prod_s[W-1:0];
          end else if (b_zero_q) begin
            hi_q <= a_q;
            lo_q <= '1;
          end else begin
            hi_q <= rem_s;
            lo_q <= quo_s;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Read port: stalls while a result is being formed
  assign rd_ready = ~busy;
  assign rd_data  = rd_sel ? hi_q : lo_q;

  logic unused_rd;
  assign unused_rd = rd_valid;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic         busy,
  input logic         rd_ready,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int LAT  = W + 1;
  localparam int CW   = $clog2(W + 2) + 1;

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  // R5: an accepted command raises busy on the next cycle
  assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  // R5: busy lasts exactly W+1 cycles
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CW'(LAT)));

  // R7: reads stall once a command has been taken
  assert_read_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !rd_ready);

  // R8: result pair holds while busy
  assert_hilo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .rd_ready  (rd_ready),
  .hi_q      (hi_q),
  .lo_q      (lo_q)
);

// File: tb/hilo_muldiv_bench.sv
`timescale 1ns/1ps
module hilo_muldiv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        busy;
  logic        rd_valid = 1'b0;
  logic        rd_sel = 1'b0;
  logic        rd_ready;
  logic [31:0] rd_data;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  hilo_muldiv u_hilo_muldiv (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Reference model: returns {HI, LO}
  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b00: begin p = 64'(sa * sb); return p; end
      2'b01: begin p = {32'b0, a} * {32'b0, b}; return p; end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        if (op == 2'b10) begin
          q = sa / sb; r = sa % sb;
          return {r[31:0], q[31:0]};
        end
        return {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string tag(input logic [1:0] op, input logic [31:0] b);
    if (!op[1]) return "R1";
    if (b == 0) return "R4";
    return (op == 2'b10) ? "R3" : "R2";
  endfunction

  task automatic read_pair(output logic [31:0] hi, output logic [31:0] lo);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_sel = 1'b1;
    #1;
    check("R7", {63'b0, rd_ready}, 64'd1);
    hi = rd_data;
    rd_sel = 1'b0;
    #1;
    lo = rd_data;
    rd_valid = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input bit poke);
    int n;
    logic [31:0] hi, lo;
    @(negedge clk);
    check("R5", {63'b0, cmd_ready}, 64'd1);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      if (poke && n == 2) begin
        cmd_valid = 1'b1; cmd_op = ~op; cmd_a = ~a; cmd_b = b + 32'd3;
        rd_valid = 1'b1; rd_sel = 1'b1;
        #1;
        check("R6", {63'b0, cmd_ready}, 64'd0);
        check("R7", {63'b0, rd_ready}, 64'd0);
      end
      if (poke && n == 4) begin
        cmd_valid = 1'b0; rd_valid = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    cmd_valid = 1'b0; rd_valid = 1'b0;
    check("R5", 64'(n), 64'd33);
    read_pair(hi, lo);
    check(poke ? "R6" : tag(op, b), {hi, lo}, model(op, a, b));
    // R8: pair unchanged once idle
    read_pair(hi, lo);
    check("R8", {hi, lo}, model(op, a, b));
  endtask

  initial begin
    logic [31:0] hi, lo;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", {62'b0, busy, cmd_ready}, 64'd1);
    read_pair(hi, lo);
    check("R9", {hi, lo}, 64'd0);

    // Directed corners
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);   // R1
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0);   // R1
    run_op(2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0);   // R1
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);   // R1
    run_op(2'b00, 32'h0000_0007, 32'hFFFF_FFFD, 1'b0);   // R1
    run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 1'b0);           // R3: q=-3 r=1
    run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 1'b0);           // R3: q=-3 r=-1
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);   // R3 overflow
    run_op(2'b10, 32'hFFFF_FF00, 32'd0, 1'b0);           // R4 signed
    run_op(2'b11, 32'h1234_5678, 32'd0, 1'b0);           // R4 unsigned
    run_op(2'b11, 32'hFFFF_FFFF, 32'd1, 1'b0);           // R2
    run_op(2'b11, 32'd5, 32'hFFFF_FFFF, 1'b0);           // R2
    run_op(2'b00, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1);   // R6 mul
    run_op(2'b10, 32'h8765_4321, 32'd17, 1'b1);          // R6 div

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      logic [1:0]  op;
      logic [31:0] a, b;
      op = 2'($urandom_range(3));
      a  = $urandom();
      case ($urandom_range(3))
        0: b = 32'($urandom_range(15));
        1: b = -32'($urandom_range(8));
        default: b = $urandom();
      endcase
      run_op(op, a, b, (i % 25) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule